// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns 48-bit virtual addresses, presented in a 64-bit field, into 48-bit physical addresses. A requester hands over one address at a time with a valid/ready handshake. It gets back a one-cycle response that carries either the physical address or a fault flag together with the level where the translation failed. Addresses whose upper sixteen bits are not copies of bit 47 are rejected straight away.

Recently used translations are kept in a small fully associative translation cache. On a cache hit no table read takes place. On a miss, a walker reads one 64-bit descriptor per level through a simple request/response memory port. The walk starts at one of two root table bases, chosen by bit 47. It stops at a 1 GB leaf, a 2 MB leaf, a 4 KB leaf or a fault. A successful walk installs its result in the cache, and the cache picks the entry to replace in round-robin order.

Top module: `vat_walker`

## Requirements
- R1: For a 4 KB page, bits 11:0 of the physical address equal bits 11:0 of the virtual address, and bits 47:12 come from bits 47:12 of the leaf descriptor.
- R2: The read at level L (0 is the top) goes to {table frame, index, 3'b000}. The index is virtual address bits [47-9L : 39-9L]. The table frame is the root base frame at level 0 and bits 47:12 of the previous descriptor at later levels.
- R3: Each walk level issues exactly one descriptor read, so a walk to a 4 KB leaf makes four reads. A new read is never issued while an earlier one is still waiting for its response.
- R4: An address whose bits 63:48 are not all equal to bit 47 returns fault=1 and level 0. It causes no memory read and responds on the second clock edge after acceptance.
- R5: Bit 47 of the virtual address selects the root: 0 uses base_lo and 1 uses base_hi.
- R6: Descriptor bit 0 is the valid bit and bit 1 is the table bit (1 = next-level table, 0 = leaf). At level 3 any valid descriptor is a 4 KB leaf, whatever the value of bit 1.
- R7: A leaf at level 1 maps a 1 GB page, and the physical address is {desc[47:30], va[29:0]}. A leaf at level 2 maps a 2 MB page, and the physical address is {desc[47:21], va[20:0]}.
- R8: An invalid descriptor, or a leaf at level 0, ends the walk with fault=1 and resp_level set to that level. A faulting translation is never cached, so repeating it repeats the reads.
- R9: A translation cache hit makes no memory read and responds on the second clock edge after acceptance. A 1 GB or 2 MB entry hits for any address inside its page.
- R10: Every successful walk fills one of TC_ENTRIES entries, chosen round-robin starting at entry 0. The entry filled TC_ENTRIES fills earlier is the one evicted.
- R11: After reset, req_ready=1, resp_valid=0 and mem_rd_valid=0. req_ready stays low from acceptance until the response. resp_valid is a single-cycle pulse. On success resp_fault=0 and resp_level=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_lo | input | 48 | Root table base for the lower half (bits 47:12 used) |
| base_hi | input | 48 | Root table base for the upper half (bits 47:12 used) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 64 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 48 | Physical address (zero on fault) |
| resp_fault | output | 1 | Translation failed |
| resp_level | output | 2 | Level at which the walk failed |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor returned by memory |

## Verification
The bench builds the block with the default TC_ENTRIES of 8. With that size, eight distinct successful walks fill the whole cache, and a ninth one brings the round-robin wrap and eviction of the oldest entry into reach inside a short run. The table images in the bench have mapped and unmapped entries at every level, plus a decoy path under the wrong root. These let each fault level, each page size and a wrong root choice show up as a wrong address or a wrong read count.

// File: rtl/vat_pkg.sv
package vat_pkg;

    localparam int FULL_VA_W = 64;
    localparam int VA_W      = 48;
    localparam int PA_W      = 48;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 9;
    localparam int LEVELS    = 4;
    localparam int LVL_W     = $clog2(LEVELS);
    localparam int DESC_W    = 64;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int FRAME_W   = PA_W - OFF_W;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef struct packed {
        logic                valid;
        logic [VPN_W-1:0]    vpn;
        pg_size_e            size;
        logic [FRAME_W-1:0]  frame;
    } tc_entry_t;

    typedef struct packed {
        logic                fault;
        logic [LVL_W-1:0]    level;
        pg_size_e            size;
        logic [FRAME_W-1:0]  frame;
    } walk_res_t;

    function automatic logic is_canonical(input logic [FULL_VA_W-1:0] va);
        return va[FULL_VA_W-1:VA_W] == {(FULL_VA_W-VA_W){va[VA_W-1]}};
    endfunction

    function automatic int page_bits(input pg_size_e s);
        case (s)
            PG_1G:   return OFF_W + 2 * IDX_W;
            PG_2M:   return OFF_W + IDX_W;
            default: return OFF_W;
        endcase
    endfunction

    function automatic pg_size_e size_for_level(input logic [LVL_W-1:0] lvl);
        case (lvl)
            LVL_W'(1): return PG_1G;
            LVL_W'(2): return PG_2M;
            default:   return PG_4K;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] level_index(input logic [VA_W-1:0] va,
                                                     input logic [LVL_W-1:0] lvl);
        logic [VA_W-1:0] sh;
        sh = va >> (OFF_W + IDX_W * (LEVELS - 1 - int'(lvl)));
        return sh[IDX_W-1:0];
    endfunction

    function automatic logic [PA_W-1:0] make_pa(input logic [FRAME_W-1:0] frame,
                                                input logic [VA_W-1:0]    va,
                                                input pg_size_e           s);
        logic [PA_W-1:0] m;
        m = (PA_W'(1) << page_bits(s)) - PA_W'(1);
        return ({frame, {OFF_W{1'b0}}} & ~m) | (va & m);
    endfunction

    function automatic logic tag_match(input logic [VPN_W-1:0] a,
                                       input logic [VPN_W-1:0] b,
                                       input pg_size_e         s);
        logic [VPN_W-1:0] m;
        m = ~((VPN_W'(1) << (page_bits(s) - OFF_W)) - VPN_W'(1));
        return ((a ^ b) & m) == '0;
    endfunction

endpackage

// File: rtl/vat_tcache.sv
module vat_tcache
    import vat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [VA_W-1:0]     lk_va,
    output logic                hit,
    output logic [PA_W-1:0]     hit_pa,
    input  logic                fill_en,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  pg_size_e            fill_size,
    input  logic [FRAME_W-1:0]  fill_frame
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tc_entry_t          ent [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   ptr_q;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = ent[g].valid &&
                              tag_match(ent[g].vpn, lk_va[VA_W-1:OFF_W], ent[g].size);
        end
    endgenerate

    // lowest matching index wins
    always_comb begin
        hit    = 1'b0;
        hit_pa = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit    = 1'b1;
                hit_pa = make_pa(ent[i].frame, lk_va, ent[i].size);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent[i].valid <= 1'b0;
            end
        end else if (fill_en) begin
            ent[ptr_q].valid <= 1'b1;
            ent[ptr_q].vpn   <= fill_vpn;
            ent[ptr_q].size  <= fill_size;
            ent[ptr_q].frame <= fill_frame;
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + PTR_W'(1);
        end
    end

endmodule

// File: rtl/vat_walk.sv
module vat_walk
    import vat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [VA_W-1:0]    va,
    input  logic [PA_W-1:0]    root,
    output logic               mem_rd_valid,
    input  logic               mem_rd_ready,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [DESC_W-1:0]  mem_rsp_data,
    output logic               done,
    output walk_res_t          res
);

    typedef enum logic [1:0] {W_IDLE, W_REQ, W_WAIT} wstate_e;

    wstate_e              st_q;
    logic [FRAME_W-1:0]   table_q;
    logic [LVL_W-1:0]     lvl_q;

    logic                 d_valid;
    logic                 d_table;
    logic [FRAME_W-1:0]   d_frame;
    logic                 unused_bits;

    assign d_valid     = mem_rsp_data[0];
    assign d_table     = mem_rsp_data[1];
    assign d_frame     = mem_rsp_data[PA_W-1:OFF_W];
    assign unused_bits = ^{mem_rsp_data[DESC_W-1:PA_W], mem_rsp_data[OFF_W-1:2], root[OFF_W-1:0]};

    assign mem_rd_valid = (st_q == W_REQ);
    assign mem_rd_addr  = {table_q, level_index(va, lvl_q), 3'b000};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= W_IDLE;
            table_q <= '0;
            lvl_q   <= '0;
            done    <= 1'b0;
            res     <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                W_IDLE: begin
                    if (start) begin
                        table_q <= root[PA_W-1:OFF_W];
                        lvl_q   <= '0;
                        st_q    <= W_REQ;
                    end
                end
                W_REQ: begin
                    if (mem_rd_ready) st_q <= W_WAIT;
                end
                W_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!d_valid || (!d_table && lvl_q == '0)) begin
                            res.fault <= 1'b1;
                            res.level <= lvl_q;
                            res.size  <= PG_4K;
                            res.frame <= '0;
                            done      <= 1'b1;
                            st_q      <= W_IDLE;
                        end else if (d_table && lvl_q != LVL_W'(LEVELS - 1)) begin
                            table_q <= d_frame;
                            lvl_q   <= lvl_q + LVL_W'(1);
                            st_q    <= W_REQ;
                        end else begin
                            res.fault <= 1'b0;
                            res.level <= lvl_q;
                            res.size  <= size_for_level(lvl_q);
                            res.frame <= d_frame;
                            done      <= 1'b1;
                            st_q      <= W_IDLE;
                        end
                    end
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vat_walker.sv
module vat_walker
    import vat_pkg::*;
#(
    parameter int TC_ENTRIES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PA_W-1:0]       base_lo,
    input  logic [PA_W-1:0]       base_hi,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [FULL_VA_W-1:0]  req_vaddr,
    output logic                  resp_valid,
    output logic [PA_W-1:0]       resp_paddr,
    output logic                  resp_fault,
    output logic [LVL_W-1:0]      resp_level,
    output logic                  mem_rd_valid,
    input  logic                  mem_rd_ready,
    output logic [PA_W-1:0]       mem_rd_addr,
    input  logic                  mem_rsp_valid,
    input  logic [DESC_W-1:0]     mem_rsp_data
);

    typedef enum logic [1:0] {T_IDLE, T_CHECK, T_WALK} tstate_e;

    tstate_e                st_q;
    logic [FULL_VA_W-1:0]   va_q;
    logic                   canon;
    logic                   tc_hit;
    logic [PA_W-1:0]        tc_pa;
    logic                   walk_start;
    logic                   walk_done;
    walk_res_t              walk_res;
    logic [PA_W-1:0]        root_sel;
    logic                   fill_en;

    assign req_ready  = (st_q == T_IDLE);
    assign canon      = is_canonical(va_q);
    assign walk_start = (st_q == T_CHECK) && canon && !tc_hit;
    assign root_sel   = va_q[VA_W-1] ? base_hi : base_lo;
    assign fill_en    = walk_done && !walk_res.fault;

    vat_tcache #(.ENTRIES(TC_ENTRIES)) u_tc (
        .clk        (clk),
        .rst        (rst),
        .lk_va      (va_q[VA_W-1:0]),
        .hit        (tc_hit),
        .hit_pa     (tc_pa),
        .fill_en    (fill_en),
        .fill_vpn   (va_q[VA_W-1:OFF_W]),
        .fill_size  (walk_res.size),
        .fill_frame (walk_res.frame)
    );

    vat_walk u_walk (
        .clk           (clk),
        .rst           (rst),
        .start         (walk_start),
        .va            (va_q[VA_W-1:0]),
        .root          (root_sel),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (walk_done),
        .res           (walk_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= T_IDLE;
            va_q       <= '0;
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_fault <= 1'b0;
            resp_level <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (st_q)
                T_IDLE: begin
                    if (req_valid) begin
                        va_q <= req_vaddr;
                        st_q <= T_CHECK;
                    end
                end
                T_CHECK: begin
                    if (!canon) begin
                        resp_valid <= 1'b1;
                        resp_paddr <= '0;
                        resp_fault <= 1'b1;
                        resp_level <= '0;
                        st_q       <= T_IDLE;
                    end else if (tc_hit) begin
                        resp_valid <= 1'b1;
                        resp_paddr <= tc_pa;
                        resp_fault <= 1'b0;
                        resp_level <= '0;
                        st_q       <= T_IDLE;
                    end else begin
                        st_q <= T_WALK;
                    end
                end
                T_WALK: begin
                    if (walk_done) begin
                        resp_valid <= 1'b1;
                        resp_fault <= walk_res.fault;
                        resp_level <= walk_res.fault ? walk_res.level : '0;
                        resp_paddr <= walk_res.fault ? '0 :
                                      make_pa(walk_res.frame, va_q[VA_W-1:0], walk_res.size);
                        st_q       <= T_IDLE;
                    end
                end
                default: st_q <= T_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vat_walker_chk.sv
module vat_walker_chk
    import vat_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [FULL_VA_W-1:0]  req_vaddr,
    input logic                  resp_valid,
    input logic                  resp_fault,
    input logic [LVL_W-1:0]      resp_level,
    input logic                  mem_rd_valid,
    input logic                  mem_rd_ready,
    input logic [PA_W-1:0]       mem_rd_addr,
    input logic                  mem_rsp_valid
);

    logic busy_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (req_valid && req_ready) busy_q <= 1'b1;
            else if (resp_valid)        busy_q <= 1'b0;
            if (mem_rd_valid && mem_rd_ready) pend_q <= 1'b1;
            else if (mem_rsp_valid)           pend_q <= 1'b0;
        end
    end

    AST_ONE_READ_PENDING: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !mem_rd_valid); // R3

    AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !mem_rd_valid); // R3

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R3

    AST_NONCANON_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !is_canonical(req_vaddr))
        |=> !mem_rd_valid ##1 (resp_valid && resp_fault && resp_level == '0)); // R4

    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !resp_valid) |-> !req_ready); // R11

endmodule

bind vat_walker vat_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .resp_valid    (resp_valid),
    .resp_fault    (resp_fault),
    .resp_level    (resp_level),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/vat_walker_test.sv
module vat_walker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] base_lo = 48'h0000_0010_0000;
    logic [47:0] base_hi = 48'h0000_0020_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic        resp_valid;
    logic [47:0] resp_paddr;
    logic        resp_fault;
    logic [1:0]  resp_level;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b1;
    logic [47:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #10 clk = ~clk; // 50 MHz

    vat_walker #(.TC_ENTRIES(8)) uut (.*);

    int checks = 0;
    int fails  = 0;
    int rd_count = 0;
    bit finished = 0;
    logic [63:0] mem [logic [47:0]];

    function automatic logic [63:0] mkva(int i0, int i1, int i2, int i3, int off);
        logic [47:0] v;
        v = {9'(i0), 9'(i1), 9'(i2), 9'(i3), 12'(off)};
        return {{16{v[47]}}, v};
    endfunction

    function automatic logic [47:0] pa_of(logic [47:0] base, logic [63:0] va, int bits);
        return base | (va[47:0] & ((48'd1 << bits) - 48'd1));
    endfunction

    typedef struct packed {
        logic [63:0] va;
        logic [47:0] pa;
        logic        flt;
        logic [1:0]  lvl;
        logic [3:0]  nrd;
        logic [1:0]  lat;   // 2 = check hit latency, 0 = skip
        logic [31:0] tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{mkva(1,2,3,4,12'hABC), 48'h0ABC_DABC, 1'b0, 2'd0, 4'd4, 2'd0, "R2"},
        '{mkva(1,2,3,4,12'hABC), 48'h0ABC_DABC, 1'b0, 2'd0, 4'd0, 2'd2, "R9"},
        '{mkva(1,2,3,4,12'h123), 48'h0ABC_D123, 1'b0, 2'd0, 4'd0, 2'd2, "R1"},
        '{mkva(1,5,9'h11,9'h22,12'h345), pa_of(48'h4000_0000, mkva(1,5,9'h11,9'h22,12'h345), 30), 1'b0, 2'd0, 4'd2, 2'd0, "R7"},
        '{mkva(1,5,9'h1F0,1,0), pa_of(48'h4000_0000, mkva(1,5,9'h1F0,1,0), 30), 1'b0, 2'd0, 4'd0, 2'd2, "R9"},
        '{mkva(1,2,7,9'h55,12'h777), pa_of(48'h8060_0000, mkva(1,2,7,9'h55,12'h777), 21), 1'b0, 2'd0, 4'd3, 2'd0, "R7"},
        '{mkva(1,2,3,9,12'h010), 48'h0123_4010, 1'b0, 2'd0, 4'd4, 2'd0, "R6"},
        '{mkva(8,0,0,0,0), 48'h0, 1'b1, 2'd0, 4'd1, 2'd0, "R8"},
        '{mkva(1,6,0,0,0), 48'h0, 1'b1, 2'd1, 4'd2, 2'd0, "R8"},
        '{mkva(1,2,10,0,0), 48'h0, 1'b1, 2'd2, 4'd3, 2'd0, "R8"},
        '{mkva(8,0,0,0,0), 48'h0, 1'b1, 2'd0, 4'd1, 2'd0, "R8"},
        '{mkva(259,0,3,4,5), pa_of(48'hC000_0000, mkva(259,0,3,4,5), 30), 1'b0, 2'd0, 4'd2, 2'd0, "R5"},
        '{64'h0001_0000_0000_0000, 48'h0, 1'b1, 2'd0, 4'd0, 2'd2, "R4"},
        '{64'hFFFF_7FFF_FFFF_F000, 48'h0, 1'b1, 2'd0, 4'd0, 2'd2, "R4"}
    };

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [47:0] addr, input logic [63:0] d);
        mem[addr] = d;
    endtask

    // memory responder: always ready, data one cycle after acceptance
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_rd_valid) begin
                logic [47:0] a;
                a = mem_rd_addr;
                rd_count++;
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
            end
        end
    end

    task automatic xlate(input logic [63:0] va, output logic [47:0] pa, output logic flt,
                         output logic [1:0] lvl, output int nrd, output int lat);
        bit saw_ready;
        @(negedge clk);
        rd_count  = 0;
        req_vaddr = va;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        saw_ready = 0;
        while (!resp_valid && lat < 200) begin
            if (req_ready) saw_ready = 1;
            @(negedge clk);
            lat++;
        end
        if (lat >= 200) chk("R11", "response timeout", 64'(lat), 64'd0);
        pa  = resp_paddr;
        flt = resp_fault;
        lvl = resp_level;
        nrd = rd_count;
        chk("R11", "ready while busy", 64'(saw_ready), 64'd0);
        @(negedge clk);
        chk("R11", "resp pulse width", 64'(resp_valid), 64'd0);
    endtask

    task automatic run_one(input string req, input logic [63:0] va, input logic [47:0] epa,
                           input logic eflt, input logic [1:0] elvl, input int enrd, input int elat);
        logic [47:0] pa;
        logic flt;
        logic [1:0] lvl;
        int nrd, lat;
        xlate(va, pa, flt, lvl, nrd, lat);
        chk(req, "fault", 64'(flt), 64'(eflt));
        chk(req, "level", 64'(lvl), 64'(elvl));
        chk(req, "paddr", 64'(pa), 64'(epa));
        chk(req, "R3 read count", 64'(nrd), 64'(enrd));
        if (elat != 0) chk(req, "latency", 64'(lat), 64'(elat));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // lower-half tables
        put(48'h10_0008, 64'h10_1003);          // L0 idx1 -> table
        put(48'h10_0040, 64'h5000_0001);        // L0 idx8 leaf at top
        put(48'h10_0818, 64'h30_1003);          // L0 idx259 decoy
        put(48'h30_1000, 64'h1_0000_0001);      // decoy 1 GB leaf
        put(48'h10_1010, 64'h10_2003);          // L1 idx2 -> table
        put(48'h10_1028, 64'h4000_0001);        // L1 idx5 1 GB leaf
        put(48'h10_2018, 64'h10_3003);          // L2 idx3 -> table
        put(48'h10_2038, 64'h8060_0001);        // L2 idx7 2 MB leaf
        put(48'h10_3020, 64'hABC_D001);         // L3 idx4 leaf
        put(48'h10_3048, 64'h123_4003);         // L3 idx9 table bit set
        for (int i = 20; i < 24; i++) put(48'h10_3000 + 48'(i * 8), 64'h50_0001 + 64'(i) * 64'h1000);
        // upper-half tables
        put(48'h20_0818, 64'h20_1003);          // L0 idx259 -> table
        put(48'h20_1000, 64'hC000_0001);        // L1 idx0 1 GB leaf

        repeat (3) @(negedge clk);
        chk("R11", "reset req_ready", 64'(req_ready), 64'd1);
        chk("R11", "reset resp_valid", 64'(resp_valid), 64'd0);
        chk("R11", "reset mem_rd_valid", 64'(mem_rd_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "idle req_ready", 64'(req_ready), 64'd1);

        for (int v = 0; v < NV; v++) begin
            run_one($sformatf("%s", VEC[v].tag), VEC[v].va, VEC[v].pa, VEC[v].flt,
                    VEC[v].lvl, int'(VEC[v].nrd), int'(VEC[v].lat));
        end

        // R10: five entries filled above; three more fill the cache, a fourth wraps to entry 0
        for (int i = 20; i < 24; i++) begin
            run_one("R10", mkva(1,2,3,i,12'h044), 48'h50_0044 + 48'(i) * 48'h1000, 1'b0, 2'd0, 4, 0);
        end
        run_one("R10", mkva(1,5,9'h11,9'h22,12'h345),
                pa_of(48'h4000_0000, mkva(1,5,9'h11,9'h22,12'h345), 30), 1'b0, 2'd0, 0, 2);
        run_one("R10", mkva(1,2,3,20,12'h001), 48'h51_4001, 1'b0, 2'd0, 0, 2);
        run_one("R10", mkva(1,2,3,4,12'hABC), 48'h0ABC_DABC, 1'b0, 2'd0, 4, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule